// File: doc/BRIEF.md
# Three-Wire Addressed Control-Register Port

This block is a write-only serial configuration slave. A host drives three lines: a serial clock, a mode line and a data line. The block samples them on its own fast system clock after a synchroniser, and collects bits into bytes, least significant bit first, on each rising edge of the serial clock. While the mode line is low, a completed byte is an address byte. While it is high, a completed byte is a data byte.

An address byte selects or deselects the port and picks a register bank. Its upper six bits must match the device address 000101, and its two low bits give the bank: status or data. Each later data byte picks a register inside that bank with its two top bits, and carries the new value in the remaining six. The registers drive the configuration outputs: the system-clock ratio select, the serial input-format select, a 6-bit volume attenuation code, a de-emphasis select and a mute flag.

Top module: `tw_ctl_port`

## Requirements
- R1: After reset the outputs are: volume 0, mute 0, de-emphasis 00, clock select 10 and format 000.
- R2: Serial data is taken on each rising edge of the synchronised serial clock, least significant bit first. No register changes until the eighth bit of a byte has been taken.
- R3: An address byte (mode low) whose bits 7:2 equal 000101 selects the port. Any other value in those bits deselects it, and data bytes then change no register.
- R4: Bits 1:0 of the address byte choose the bank: 10 is the status bank and 00 is the data bank. With 01 or 11, data bytes change no register.
- R5: A selection stays in force for any number of data bytes, until the next address byte arrives.
- R6: In the status bank, a data byte with bits 7:6 = 00 writes the clock select from bits 5:4 and the format from bits 3:1. Status bytes with any other selector change nothing.
- R7: In the data bank, selector 00 writes the volume code from bits 5:0.
- R8: In the data bank, selector 10 writes the de-emphasis from bits 4:3 and the mute flag from bit 2. Selectors 01 and 11 change nothing.
- R9: Low on the mode line means an address byte and high means a data byte. Any change on the mode line clears the bit count, and the bits of an unfinished byte are discarded.
- R10: If a mode-line change and a serial-clock rise fall in the same synchronised cycle, the mode change wins and the bit on that rise is dropped.
- R11: Each output reaches its new value on the fourth system clock edge after the eighth serial-clock rise is applied (default of two synchroniser stages).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_clk | input | 1 | Serial control clock, asynchronous |
| ctl_mode | input | 1 | Mode line: 0 means address byte, 1 means data byte |
| ctl_data | input | 1 | Serial data, least significant bit first |
| sysclk_sel | output | 2 | System clock ratio select (00 512fs, 01 384fs, 10 256fs) |
| fmt_sel | output | 3 | Serial input format select |
| vol_code | output | 6 | Volume attenuation code |
| deemph_sel | output | 2 | De-emphasis (00 off, 01 32 kHz, 10 44.1 kHz, 11 48 kHz) |
| mute_en | output | 1 | Mute enable |

## Verification
The two functions that can meet in one synchronised cycle are the bit-count clear caused by a mode-line change and the bit capture caused by a serial-clock rise. The bench raises the serial clock in the same system cycle in which it flips the mode line from data to address. It then sends a full address byte and a volume byte. If the dropped bit had been counted, every later byte would be misaligned and the volume would come out wrong. A behavioural model tracks both events and is compared against all outputs on every clock, so the drop is judged both by cycle timing and by the final register value.

// File: rtl/tw_cfg_pkg.sv
`timescale 1ns/1ps
package tw_cfg_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 2;

    typedef enum logic [1:0] {
        XFER_DATA   = 2'b00,
        XFER_NONE_A = 2'b01,
        XFER_STATUS = 2'b10,
        XFER_NONE_B = 2'b11
    } xfer_e;

    typedef struct packed {
        logic [1:0] clk_sel;
        logic [2:0] fmt;
        logic [5:0] vol;
        logic [1:0] deemph;
        logic       mute;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{clk_sel: 2'b10, fmt: 3'b000, vol: 6'd0,
                                   deemph: 2'b00, mute: 1'b0};
endpackage

// File: rtl/tw_sync.sv
`timescale 1ns/1ps
module tw_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] st_d [STAGES];
    logic [W-1:0] st_q [STAGES];

    always_comb begin
        st_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                st_q[i] <= '0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/tw_shift.sv
`timescale 1ns/1ps
module tw_shift #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_clk,
    input  logic          s_mode,
    input  logic          s_data,
    output logic          byte_vld,
    output logic          byte_is_data,
    output logic [BW-1:0] byte_val
);
    localparam int CNT_W = $clog2(BW);

    typedef struct packed {
        logic             prev_clk;
        logic             prev_mode;
        logic [CNT_W-1:0] cnt;
        logic [BW-1:0]    sr;
        logic             vld;
        logic             is_data;
        logic [BW-1:0]    word;
    } st_t;

    st_t  st_d, st_q;
    logic rise, mode_chg;
    logic [BW-1:0] sr_next;

    assign rise     = s_clk & ~st_q.prev_clk;
    assign mode_chg = s_mode ^ st_q.prev_mode;
    assign sr_next  = {s_data, st_q.sr[BW-1:1]};

    always_comb begin
        st_d           = st_q;
        st_d.vld       = 1'b0;
        st_d.prev_clk  = s_clk;
        st_d.prev_mode = s_mode;
        if (mode_chg) begin
            st_d.cnt = '0;
        end else if (rise) begin
            st_d.sr = sr_next;
            if (st_q.cnt == CNT_W'(BW-1)) begin
                st_d.cnt     = '0;
                st_d.vld     = 1'b1;
                st_d.word    = sr_next;
                st_d.is_data = s_mode;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_vld     = st_q.vld;
    assign byte_is_data = st_q.is_data;
    assign byte_val     = st_q.word;

    a_r9_mode_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (st_q.cnt == '0));
    a_r10_rise_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && rise) |=> ($stable(st_q.sr) && !st_q.vld));
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |=> !st_q.vld);
endmodule

// File: rtl/tw_regs.sv
`timescale 1ns/1ps
module tw_regs
    import tw_cfg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 6'b000101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic              byte_is_data,
    input  logic [BYTE_W-1:0] byte_val,
    output cfg_t              cfg
);
    typedef struct packed {
        logic  sel;
        xfer_e xtype;
        cfg_t  cfg;
    } st_t;

    st_t        st_d, st_q;
    logic [1:0] sub;

    assign sub = byte_val[BYTE_W-1 -: 2];

    always_comb begin
        st_d = st_q;
        if (byte_vld) begin
            if (!byte_is_data) begin
                st_d.sel   = (byte_val[BYTE_W-1:2] == DEV_ADDR);
                st_d.xtype = xfer_e'(byte_val[1:0]);
            end else if (st_q.sel) begin
                case (st_q.xtype)
                    XFER_STATUS: begin
                        if (sub == 2'b00) begin
                            st_d.cfg.clk_sel = byte_val[5:4];
                            st_d.cfg.fmt     = byte_val[3:1];
                        end
                    end
                    XFER_DATA: begin
                        case (sub)
                            2'b00: st_d.cfg.vol = byte_val[5:0];
                            2'b10: begin
                                st_d.cfg.deemph = byte_val[4:3];
                                st_d.cfg.mute   = byte_val[2];
                            end
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel   <= 1'b0;
            st_q.xtype <= XFER_NONE_A;
            st_q.cfg   <= CFG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.cfg;

    a_r2_cfg_holds_between_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> $stable(st_q.cfg));
    a_r5_select_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_vld || byte_is_data) |=> ($stable(st_q.sel) && $stable(st_q.xtype)));
    a_r3_foreign_deselects: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !byte_is_data && (byte_val[BYTE_W-1:2] != DEV_ADDR)) |=> !st_q.sel);
    a_r4_unbanked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_is_data &&
         (st_q.xtype == XFER_NONE_A || st_q.xtype == XFER_NONE_B)) |=> $stable(st_q.cfg));
    a_r8_reserved_selector: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_is_data && st_q.xtype == XFER_DATA &&
         (sub == 2'b01 || sub == 2'b11)) |=> $stable(st_q.cfg));
endmodule

// File: rtl/tw_ctl_port.sv
`timescale 1ns/1ps
module tw_ctl_port
    import tw_cfg_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 6'b000101
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_clk,
    input  logic       ctl_mode,
    input  logic       ctl_data,
    output logic [1:0] sysclk_sel,
    output logic [2:0] fmt_sel,
    output logic [5:0] vol_code,
    output logic [1:0] deemph_sel,
    output logic       mute_en
);
    logic [2:0]        synced;
    logic              b_vld, b_is_data;
    logic [BYTE_W-1:0] b_val;
    cfg_t              cfg;

    tw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ctl_clk, ctl_mode, ctl_data}),
        .dout (synced)
    );

    tw_shift #(.BW(BYTE_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .s_clk       (synced[2]),
        .s_mode      (synced[1]),
        .s_data      (synced[0]),
        .byte_vld    (b_vld),
        .byte_is_data(b_is_data),
        .byte_val    (b_val)
    );

    tw_regs #(.DEV_ADDR(DEV_ADDR)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_vld    (b_vld),
        .byte_is_data(b_is_data),
        .byte_val    (b_val),
        .cfg         (cfg)
    );

    assign sysclk_sel = cfg.clk_sel;
    assign fmt_sel    = cfg.fmt;
    assign vol_code   = cfg.vol;
    assign deemph_sel = cfg.deemph;
    assign mute_en    = cfg.mute;
endmodule

// File: tb/tw_ctl_port_bench.sv
`timescale 1ns/1ps
module tw_ctl_port_bench;
    localparam int LAT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_clk = 1'b0, ctl_mode = 1'b0, ctl_data = 1'b0;
    logic [1:0] sysclk_sel;
    logic [2:0] fmt_sel;
    logic [5:0] vol_code;
    logic [1:0] deemph_sel;
    logic       mute_en;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // behavioural model state
    int m_clkl = 0, m_mode = 0, m_cnt = 0, m_bits = 0;
    int m_sel = 0, m_type = 0;
    int e_clk = 2, e_fmt = 0, e_vol = 0, e_deem = 0, e_mute = 0;
    logic [13:0] expq [$];

    always #2 clk = ~clk;

    tw_ctl_port u_tw_ctl_port (
        .clk(clk), .rst_n(rst_n), .ctl_clk(ctl_clk), .ctl_mode(ctl_mode),
        .ctl_data(ctl_data), .sysclk_sel(sysclk_sel), .fmt_sel(fmt_sel),
        .vol_code(vol_code), .deemph_sel(deemph_sel), .mute_en(mute_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [13:0] pack_exp();
        return {e_clk[1:0], e_fmt[2:0], e_vol[5:0], e_deem[1:0], e_mute[0]};
    endfunction

    task automatic take_byte(input int b, input int mode);
        if (mode == 0) begin
            m_sel  = ((b >> 2) == 5) ? 1 : 0;
            m_type = b & 3;
        end else if (m_sel == 1) begin
            if (m_type == 2 && (b >> 6) == 0) begin
                e_clk = (b >> 4) & 3;
                e_fmt = (b >> 1) & 7;
            end else if (m_type == 0) begin
                if ((b >> 6) == 0) e_vol = b & 63;
                else if ((b >> 6) == 2) begin
                    e_deem = (b >> 3) & 3;
                    e_mute = (b >> 2) & 1;
                end
            end
        end
    endtask

    task automatic compare();
        logic [13:0] e;
        e = expq.pop_front();
        chk("R6 R11 clock select", int'(sysclk_sel), int'(e[13:12]));
        chk("R6 R11 format",       int'(fmt_sel),    int'(e[11:9]));
        chk("R7 R11 volume",       int'(vol_code),   int'(e[8:3]));
        chk("R8 R11 de-emphasis",  int'(deemph_sel), int'(e[2:1]));
        chk("R8 R11 mute",         int'(mute_en),    int'(e[0]));
    endtask

    task automatic step(input logic c, input logic m, input logic d);
        @(negedge clk);
        compare();
        ctl_clk = c; ctl_mode = m; ctl_data = d;
        if (int'(m) != m_mode) begin
            m_cnt = 0; m_bits = 0;                    // R9, R10: mode change wins
        end else if (c && m_clkl == 0) begin
            m_bits = m_bits | (int'(d) << m_cnt);
            m_cnt++;
            if (m_cnt == 8) begin
                take_byte(m_bits, int'(m));
                m_cnt = 0; m_bits = 0;
            end
        end
        m_mode = int'(m);
        m_clkl = int'(c);
        expq.push_back(pack_exp());
    endtask

    task automatic send_bit(input logic m, input logic d);
        step(1'b0, m, d); step(1'b0, m, d);
        step(1'b1, m, d); step(1'b1, m, d);
    endtask

    task automatic send_byte(input logic m, input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_bit(m, b[i]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, ctl_mode, ctl_data);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < LAT; i++) expq.push_back(pack_exp());
        // R1 reset state
        chk("R1 clock select", int'(sysclk_sel), 2);
        chk("R1 format", int'(fmt_sel), 0);
        chk("R1 volume", int'(vol_code), 0);
        chk("R1 de-emphasis", int'(deemph_sel), 0);
        chk("R1 mute", int'(mute_en), 0);

        // R2: data bank, volume split across an idle gap
        send_byte(1'b0, 8'h14);
        for (int i = 0; i < 7; i++) send_bit(1'b1, i[0] ? 1'b1 : (i == 4 ? 1'b0 : 1'b0));
        idle(8);
        chk("R2 no write before eighth bit", int'(vol_code), 0);
        send_bit(1'b1, 1'b0);
        idle(6);
        chk("R2 R7 volume after byte", int'(vol_code), 42);

        // R8, R5: de-emphasis and mute under the same selection
        send_byte(1'b1, 8'h94);
        idle(6);
        chk("R8 de-emphasis", int'(deemph_sel), 2);
        chk("R8 mute", int'(mute_en), 1);
        chk("R5 volume kept", int'(vol_code), 42);
        send_byte(1'b1, 8'h7F);
        send_byte(1'b1, 8'hC0);
        idle(6);
        chk("R8 reserved selectors volume", int'(vol_code), 42);
        chk("R8 reserved selectors mute", int'(mute_en), 1);

        // R6: status bank
        send_byte(1'b0, 8'h16);
        send_byte(1'b1, 8'h16);
        idle(6);
        chk("R6 clock select", int'(sysclk_sel), 1);
        chk("R6 format", int'(fmt_sel), 3);
        send_byte(1'b1, 8'h7E);
        idle(6);
        chk("R6 other selector ignored", int'(fmt_sel), 3);

        // R3: foreign address
        send_byte(1'b0, 8'h1C);
        send_byte(1'b1, 8'h01);
        idle(6);
        chk("R3 foreign address ignored", int'(vol_code), 42);

        // R4: unbanked type codes
        send_byte(1'b0, 8'h15);
        send_byte(1'b1, 8'h01);
        send_byte(1'b0, 8'h17);
        send_byte(1'b1, 8'h03);
        idle(6);
        chk("R4 type codes 01 and 11 ignored", int'(vol_code), 42);
        chk("R4 status unchanged", int'(sysclk_sel), 1);

        // R9: partial byte discarded by mode change
        send_byte(1'b0, 8'h14);
        send_bit(1'b1, 1'b1); send_bit(1'b1, 1'b1); send_bit(1'b1, 1'b1);
        idle(6);
        chk("R9 partial byte no effect", int'(vol_code), 42);
        send_byte(1'b0, 8'h14);
        send_byte(1'b1, 8'h09);
        idle(6);
        chk("R9 realigned volume", int'(vol_code), 9);

        // R10: mode change and clock rise in the same cycle
        step(1'b1, 1'b0, 1'b1); step(1'b1, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0); step(1'b0, 1'b0, 1'b0);
        send_byte(1'b0, 8'h14);
        send_byte(1'b1, 8'h0C);
        idle(6);
        chk("R10 dropped bit keeps alignment", int'(vol_code), 12);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule